// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Set/Clear Enables

This block gathers 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. The sources are split into two banks of 32. Bit n of a low-bank register refers to source n, and bit n of a high-bank register refers to source 32+n.

Each source has a pending latch that is set by a rising edge on its request line. It also has an enable bit and a select bit, where the select bit chooses which processor output the source drives. Software changes the enable mask only by writing ones to a set register or to a clear register, so it never needs a read-modify-write sequence. A latched request is acknowledged through its own write-one-to-clear register. Because acknowledge and masking are separate, a handler can mask a source, acknowledge it and then re-enable it as three independent steps.

The register port is a plain 32-bit interface. A write takes effect on the clock edge at which it is presented. A read is combinational from the address.

Top module: `banked_intc`

## Requirements
- R1: Bit n of a low-bank register (offsets 0x80, 0x98, 0xA0, 0xA8, 0xD8) refers to source n. Bit n of a high-bank register (the same offset plus 4) refers to source 32+n.
- R2: A 0-to-1 change on a request line, sampled at a clock edge, sets that source's pending latch at the same edge. The latch stays set after the line drops. A line held high does not set the latch again once it has been acknowledged.
- R3: Reading the status registers (0x80 low, 0x84 high) returns pending AND enabled for each source. A pending source that is disabled reads 0.
- R4: Writing the enable-set registers (0xA0 low, 0xA4 high) enables every source whose data bit is 1 and leaves the others unchanged. Reading these registers returns the current enable mask.
- R5: Writing the enable-clear registers (0xA8 low, 0xAC high) disables every source whose data bit is 1 and leaves the others unchanged. Writing all ones disables the whole bank. Reading these registers returns 0.
- R6: Writing the acknowledge registers (0xD8 low, 0xDC high) clears the pending latch of every source whose data bit is 1. Bits written as 0 have no effect. Reading these registers returns 0.
- R7: The select registers (0x98 low, 0x9C high) are read/write. A select bit of 1 routes the source to the fast interrupt output, and a select bit of 0 routes it to the normal interrupt output.
- R8: irq_o is the OR of the status bits whose select bit is 0. fiq_o is the OR of the status bits whose select bit is 1. Both outputs are low when no status bit is set.
- R9: After reset, all pending, enable and select bits are 0, every readable register returns 0, and both outputs are low.
- R10: When a rising edge and an acknowledge of the same source occur at the same clock edge, the pending latch stays set.
- R11: Masking, acknowledging and re-enabling a source are independent writes. After it is acknowledged while masked, the source stays silent when it is re-enabled.
- R12: Reads of any offset other than the ten listed above return 0. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Request lines, one per source |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The hardest case to reach from the ports is a new rising edge arriving at the same clock edge as an acknowledge of that source. The stimulus raises the request line in the same cycle that the acknowledge write is presented, then reads the status back. A related case is an acknowledge issued while the source is masked. To reach it, the bench masks a source while its line is still held high, acknowledges it, and re-enables it. It then reads the status and checks that nothing reappears. The sweep walks every one of the 64 sources through a full lifecycle: select, raise, enable, drop, acknowledge. A shadow model in the bench tracks the expected state throughout, so any crossing of the bank mapping shows up in the other bank's status.

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int BANK_W    = 32,
  parameter int NBANK     = 2,
  parameter int ADDR_W    = 8,
  parameter int STAT_OFS  = 'h80,
  parameter int SEL_OFS   = 'h98,
  parameter int ENSET_OFS = 'hA0,
  parameter int ENCLR_OFS = 'hA8,
  parameter int ACK_OFS   = 'hD8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BANK_W*NBANK-1:0] src_req,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [BANK_W-1:0]       wdata,
  output logic [BANK_W-1:0]       rdata,
  output logic                    irq_o,
  output logic                    fiq_o
);
  localparam int NSRC = BANK_W * NBANK;

  logic [NSRC-1:0] pend_q, en_q, sel_q, prev_q;
  logic [NSRC-1:0] set_m, clr_m, ack_m, sel_m, rise, status;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    assign set_m[LO +: BANK_W] = (wr_en && addr == ADDR_W'(ENSET_OFS + 4*b)) ? wdata : '0;
    assign clr_m[LO +: BANK_W] = (wr_en && addr == ADDR_W'(ENCLR_OFS + 4*b)) ? wdata : '0;
    assign ack_m[LO +: BANK_W] = (wr_en && addr == ADDR_W'(ACK_OFS + 4*b))   ? wdata : '0;
    assign sel_m[LO +: BANK_W] = {BANK_W{wr_en && addr == ADDR_W'(SEL_OFS + 4*b)}};
  end

  assign rise   = src_req & ~prev_q;
  assign status = pend_q & en_q;
  assign irq_o  = |(status & ~sel_q);
  assign fiq_o  = |(status & sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
    end else begin
      prev_q <= src_req;
      pend_q <= (pend_q & ~ack_m) | rise;
      en_q   <= (en_q | set_m) & ~clr_m;
      sel_q  <= (sel_q & ~sel_m) | ({NBANK{wdata}} & sel_m);
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(STAT_OFS + 4*b))  rdata = status[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(SEL_OFS + 4*b))   rdata = sel_q[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(ENSET_OFS + 4*b)) rdata = en_q[b*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
  parameter int BANK_W    = 32,
  parameter int NBANK     = 2,
  parameter int ADDR_W    = 8,
  parameter int STAT_OFS  = 'h80,
  parameter int ENSET_OFS = 'hA0,
  parameter int ENCLR_OFS = 'hA8,
  parameter int ACK_OFS   = 'hD8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [BANK_W*NBANK-1:0] src_req,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wr_en,
  input logic [BANK_W-1:0]       wdata,
  input logic [BANK_W-1:0]       rdata,
  input logic                    irq_o,
  input logic                    fiq_o,
  input logic [BANK_W*NBANK-1:0] pend_q,
  input logic [BANK_W*NBANK-1:0] en_q,
  input logic [BANK_W*NBANK-1:0] sel_q
);
  logic [BANK_W*NBANK-1:0] src_d, rise_c;

  always_ff @(posedge clk) begin
    if (!rst_n) src_d <= '0;
    else        src_d <= src_req;
  end
  assign rise_c = src_req & ~src_d;

  p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_c) |=> ((pend_q & $past(rise_c)) == $past(rise_c)));

  p_enset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ENSET_OFS)) |=>
      ((en_q[BANK_W-1:0] & $past(wdata)) == $past(wdata)));

  p_enclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ENCLR_OFS)) |=>
      ((en_q[BANK_W-1:0] & $past(wdata)) == '0));

  // R6 and R10: acknowledged bits clear unless a fresh edge arrived
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ACK_OFS)) |=>
      ((pend_q[BANK_W-1:0] & $past(wdata) & ~$past(rise_c[BANK_W-1:0])) == '0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & en_q)) |-> (!irq_o && !fiq_o));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < ADDR_W'(STAT_OFS)) |=> ($stable(en_q) && $stable(sel_q)));
endmodule

bind banked_intc banked_intc_chk #(.BANK_W(BANK_W), .NBANK(NBANK), .ADDR_W(ADDR_W))
  u_chk (.*);

// File: tb/banked_intc_bench.sv
`timescale 1ns/1ps
module banked_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_req = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [63:0] m_pend = '0, m_en = '0, m_sel = '0, m_prev = '0;

  always #4 clk = ~clk;

  banked_intc u_banked_intc (.*);

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h80: return (m_pend & m_en) >> 0;
      8'h84: return (m_pend & m_en) >> 32;
      8'h98: return m_sel[31:0];
      8'h9C: return m_sel[63:32];
      8'hA0: return m_en[31:0];
      8'hA4: return m_en[63:32];
      default: return '0;
    endcase
  endfunction

  function automatic bit is_mapped(logic [7:0] a);
    return a inside {8'h80, 8'h84, 8'h98, 8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hD8, 8'hDC};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with optional write; the model follows the requirement rules
  task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d);
    logic [63:0] r, wide, ack, set, clr;
    wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    wide = {d, d};
    r   = src_req & ~m_prev;
    ack = !wr ? '0 : a == 8'hD8 ? {32'h0, d} : a == 8'hDC ? {d, 32'h0} : '0;
    set = !wr ? '0 : a == 8'hA0 ? {32'h0, d} : a == 8'hA4 ? {d, 32'h0} : '0;
    clr = !wr ? '0 : a == 8'hA8 ? {32'h0, d} : a == 8'hAC ? {d, 32'h0} : '0;
    if (wr && a == 8'h98) m_sel[31:0]  = d;
    if (wr && a == 8'h9C) m_sel[63:32] = d;
    m_pend = (m_pend & ~ack) | r;
    m_en   = (m_en | set) & ~clr;
    m_prev = src_req;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    addr = a; #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic out_chk(string req);
    chk({req, " irq"}, {31'b0, irq_o}, {31'b0, |(m_pend & m_en & ~m_sel)});
    chk({req, " fiq"}, {31'b0, fiq_o}, {31'b0, |(m_pend & m_en & m_sel)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    foreach (m_pend[i]) if (i < 6) rd_chk("R9", 8'h80 + 8'(i < 2 ? 4*i : i < 4 ? 24 + 4*(i-2) : 32 + 4*(i-4)));
    out_chk("R9");

    // R1 R2 R3 R4 R6 R7 R8: full lifecycle of each source
    for (int s = 0; s < 64; s++) begin
      logic [7:0] bo = 8'(4 * (s / 32));
      logic [31:0] m = 32'h1 << (s % 32);
      if (s % 3 == 0) begin
        cyc(1, 8'h98 + bo, exp_read(8'h98 + bo) | m);
        rd_chk("R7", 8'h98 + bo);
      end
      src_req[s] = 1'b1; cyc(0, 8'h00, 0);
      rd_chk("R3", 8'h80 + bo);
      cyc(1, 8'hA0 + bo, m);
      rd_chk("R4", 8'hA0 + bo);
      rd_chk("R1", 8'h80); rd_chk("R1", 8'h84);
      out_chk("R8");
      src_req[s] = 1'b0; cyc(0, 8'h00, 0);
      rd_chk("R2", 8'h80 + bo);
      cyc(1, 8'hD8 + bo, m);
      rd_chk("R6", 8'h80 + bo);
      out_chk("R8");
      src_req[s] = 1'b1; cyc(0, 8'h00, 0);
      cyc(1, 8'hD8 + bo, m);
      cyc(0, 8'h00, 0);
      rd_chk("R2", 8'h80 + bo);
      src_req[s] = 1'b0; cyc(0, 8'h00, 0);
    end

    // R5: bulk disable
    src_req = '1; cyc(0, 8'h00, 0);
    rd_chk("R5", 8'h84);
    cyc(1, 8'hA8, 32'hFFFF_FFFF);
    rd_chk("R5", 8'hA0); rd_chk("R5", 8'h80); rd_chk("R5", 8'h84);
    rd_chk("R5", 8'hA8);
    cyc(1, 8'hAC, 32'hFFFF_FFFF);
    rd_chk("R5", 8'hA4); out_chk("R5");

    // R11: mask, acknowledge, re-enable source 5
    cyc(1, 8'hA0, 32'h20); rd_chk("R11", 8'h80); out_chk("R11");
    cyc(1, 8'hA8, 32'h20); rd_chk("R11", 8'h80); out_chk("R11");
    cyc(1, 8'hD8, 32'h20);
    cyc(1, 8'hA0, 32'h20); rd_chk("R11", 8'h80); out_chk("R11");
    rd_chk("R11", 8'hA0);
    src_req = '0; cyc(0, 8'h00, 0);

    // R10: edge and acknowledge of source 40 in one cycle
    cyc(1, 8'hA4, 32'h100);
    cyc(1, 8'hDC, 32'h100);
    src_req[40] = 1'b1;
    cyc(1, 8'hDC, 32'h100);
    rd_chk("R10", 8'h84); out_chk("R10");
    cyc(1, 8'hDC, 32'h100);
    rd_chk("R10", 8'h84);

    // R6 R4 R5: zero-bit writes change nothing
    cyc(1, 8'hA0, 32'hFFFF_FFFF);
    cyc(1, 8'hD8, 32'h0); rd_chk("R6", 8'h80);
    cyc(1, 8'hA8, 32'h0); rd_chk("R5", 8'hA0);
    cyc(1, 8'hA0, 32'h0); rd_chk("R4", 8'hA0);

    // R12: unmapped offsets
    for (int a = 0; a < 256; a += 4) begin
      if (!is_mapped(8'(a))) begin
        cyc(1, 8'(a), 32'hFFFF_FFFF);
        rd_chk("R12", 8'(a));
      end
    end
    rd_chk("R12", 8'h80); rd_chk("R12", 8'h84); rd_chk("R12", 8'h98);
    rd_chk("R12", 8'h9C); rd_chk("R12", 8'hA0); rd_chk("R12", 8'hA4);
    rd_chk("R12", 8'hDC); out_chk("R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule